// File: doc/BRIEF.md
# Shared-Counter Edge-Aligned PWM Timer

This block is a register-programmed PWM generator. A single up-counter, clocked through a power-of-two prescaler, runs from zero to a programmable terminal value and then wraps. Every channel compares that shared count against its own compare value to produce an edge-aligned waveform. All channels therefore have the same period, and each channel has its own duty and polarity.

Software reaches the block through a 32-bit single-cycle write strobe and a combinational read port. The terminal value and the compare values are double-buffered. While the counter is stopped, a write takes effect at once. While a counter mode is selected, a write is parked until the counter next wraps, and a read returns the value currently in force, so a driver can poll for completion. Polarity and enable settings in a channel's control register take effect on the next cycle. Each channel also has a sticky match flag that is cleared by writing a one to it.

Top module: `shared_pwm_timer`

## Requirements
- R1: After reset, the registers at 0x10, 0x14, 0x18 and every channel register read 0, and all PWM outputs are low. Bits [7:0] at offset 0x04 always read the channel count (NUM_CH).
- R2: Control register 0x10 has two fields. Bits [2:0] are the prescale select ps, and bits [4:3] are the counter mode. With mode 2'b01 the count advances once every 2^ps clocks. Any other mode holds the count. Bit 5 ignores writes and reads 0.
- R3: The count, readable at 0x14, goes 0, 1, ... up to the active terminal value and then back to 0. Writes to 0x14 are ignored.
- R4: A channel with control bit 5 = 1 and bits [3:2] = 2'b10 (normal polarity) drives high while the count is below its compare value and low otherwise.
- R5: The terminal value (0x18, 16 bits) and a channel's compare value (0x24 + 8·n) apply on the next cycle when the mode is 2'b00. In any other mode they apply when the counter wraps. Both registers read back the value currently in force.
- R6: A compare value of 0 gives a constant inactive level. A compare value above the terminal value gives a constant active level.
- R7: Bits [3:2] = 2'b01 (inverted polarity) drive the complement of R4. A polarity change shows at the output on the cycle after the write.
- R8: A channel drives low when control bit 5 is 0, or when bits [3:2] are 2'b00 or 2'b11.
- R9: Channel control bit 7 sets when the count equals the active compare value on an advancing tick. It never sets while the counter is stopped. Writing 1 to bit 7 clears it, and writing 0 to bit 7 leaves it unchanged. Channel control reads back as {flag, 0, bit5, bit4, bits[3:2], 00}.
- R10: All channels follow the same count and the same period at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH | Per-channel PWM outputs |

## Verification
The assertions assume three things about the inputs. The counter mode changes only through the control register. No more than 28 channels are built, so that the channel map fits below offset 0x100. Reset is held for at least one clock. The stimulus issues one write per strobe and reprograms the terminal value only while the counter is stopped, or through the buffered path while it runs. After the counter is parked in a non-counting mode, the stimulus rewrites the terminal value while stopped, so that no stale buffered value is pending when the counter restarts. Duty is checked by counting high cycles over whole periods. These counts do not depend on phase, so the stimulus never has to align to the counter.

// File: rtl/pwm_timer_pkg.sv
// Shared constants and types for the shared-counter PWM timer.
// Assumes: byte addressing, 8-bit offsets, channel pairs 8 bytes apart.
package pwm_timer_pkg;
    localparam int OFS_INFO    = 'h04;
    localparam int OFS_CTRL    = 'h10;
    localparam int OFS_COUNT   = 'h14;
    localparam int OFS_TERM    = 'h18;
    localparam int CH_BASE     = 'h20;
    localparam int CH_STRIDE   = 8;
    localparam int CH_VAL_OFS  = 4;

    typedef enum logic [1:0] {
        CM_STOP = 2'b00,
        CM_CLK  = 2'b01,
        CM_RSV2 = 2'b10,
        CM_RSV3 = 2'b11
    } cnt_mode_e;

    typedef struct packed {
        logic       edge_sel;
        logic       alt_sel;
        logic [1:0] lvl;
    } chan_cfg_t;

    typedef enum logic [1:0] {DRV_OFF, DRV_NORM, DRV_INV} drive_e;

    // Map a channel configuration to its output behaviour.
    function automatic drive_e cfg_drive(chan_cfg_t c);
        if (!c.edge_sel)          return DRV_OFF;
        else if (c.lvl == 2'b10)  return DRV_NORM;
        else if (c.lvl == 2'b01)  return DRV_INV;
        else                      return DRV_OFF;
    endfunction
endpackage

// File: rtl/pwm_prescale.sv
// Clock-enable prescaler: pulses tick once every 2^ps clocks while run is high.
// Assumes: the divider restarts from zero whenever run drops.
module pwm_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low ps bits of the divider all ones marks the tick clock.
    always_comb begin
        mask = ~({DIV_W{1'b1}} << ps);
        tick = run && ((div_q & mask) == mask);
    end

    // Free-running divider, cleared while the counter is not counting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + DIV_W'(1);
    end
endmodule

// File: rtl/pwm_count.sv
// Shared up-counter with a double-buffered terminal value.
// Assumes: tick only asserts while buffered is high.
module pwm_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             buffered,
    input  logic             wr_term,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] term_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q, term_buf, term_act;

    assign wrap_o = tick && (cnt_q >= term_act);
    assign cnt_o  = cnt_q;
    assign term_o = term_act;

    // Advance on each tick, restart from zero after the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (tick)  cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
    end

    // Buffer register always captures writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       term_buf <= '0;
        else if (wr_term) term_buf <= wr_data;
    end

    // Active value: direct while stopped, from the buffer at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                    term_act <= '0;
        else if (wr_term && !buffered) term_act <= wr_data;
        else if (wrap_o)               term_act <= term_buf;
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == term_act) |=> (cnt_q == '0)) else $error("wrap missed"); // R3
    AST_TERM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !wrap_o) |=> $stable(term_act)) else $error("term changed mid-period"); // R5
endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: configuration, match flag, buffered compare value, output.
// Assumes: cnt, tick and wrap come from the shared counter.
module pwm_chan
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tick,
    input  logic             buffered,
    input  logic             wrap,
    input  logic             wr_ctrl,
    input  logic             wr_val,
    input  logic [7:0]       wctrl,
    input  logic [CNT_W-1:0] wval,
    output logic [7:0]       ctrl_o,
    output logic [CNT_W-1:0] val_o,
    output logic             pwm_o
);
    chan_cfg_t        cfg_q;
    logic             flag_q;
    logic [CNT_W-1:0] val_buf, val_act;
    logic             in_duty;

    // Configuration applies immediately on write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (wr_ctrl) cfg_q <= chan_cfg_t'(wctrl[5:2]);
    end

    // Sticky match flag; a set outranks a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag_q <= 1'b0;
        else if (tick && cnt == val_act)     flag_q <= 1'b1;
        else if (wr_ctrl && wctrl[7])        flag_q <= 1'b0;
    end

    // Compare buffer captures every write.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_buf <= '0;
        else if (wr_val) val_buf <= wval;
    end

    // Active compare: direct while stopped, from the buffer at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                   val_act <= '0;
        else if (wr_val && !buffered) val_act <= wval;
        else if (wrap)                val_act <= val_buf;
    end

    // Output level from the count and the polarity setting.
    always_comb begin
        in_duty = cnt < val_act;
        unique case (cfg_drive(cfg_q))
            DRV_NORM: pwm_o = in_duty;
            DRV_INV:  pwm_o = !in_duty;
            default:  pwm_o = 1'b0;
        endcase
    end

    assign ctrl_o = {flag_q, 1'b0, cfg_q.edge_sel, cfg_q.alt_sel, cfg_q.lvl, 2'b00};
    assign val_o  = val_act;

    AST_VAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !wrap) |=> $stable(val_act)) else $error("compare changed mid-period"); // R5
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.edge_sel) |-> !pwm_o) else $error("disabled channel driving"); // R8
endmodule

// File: rtl/shared_pwm_timer.sv
// Top: register file, control register, shared counter and NUM_CH channels.
// Assumes: one-cycle write strobes, NUM_CH <= 28 so the map fits 8-bit offsets.
module shared_pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int MODE_LO = PS_W;

    logic [PS_W-1:0]  ps_q;
    cnt_mode_e        mode_q;
    logic             run, buffered, tick, wrap;
    logic [CNT_W-1:0] cnt, term;
    logic [7:0]       ch_ctrl [NUM_CH];
    logic [CNT_W-1:0] ch_val  [NUM_CH];
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata[31:CNT_W];
    assign run      = (mode_q == CM_CLK);
    assign buffered = (mode_q != CM_STOP);

    // Control register: prescale and counter mode; center-aligned bit not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q   <= '0;
            mode_q <= CM_STOP;
        end else if (bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) begin
            ps_q   <= bus_wdata[PS_W-1:0];
            mode_q <= cnt_mode_e'(bus_wdata[MODE_LO+1:MODE_LO]);
        end
    end

    pwm_prescale #(.PS_W(PS_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .run(run), .ps(ps_q), .tick(tick)
    );

    pwm_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .buffered(buffered),
        .wr_term(bus_wr && bus_addr == ADDR_W'(OFS_TERM)),
        .wr_data(bus_wdata[CNT_W-1:0]),
        .cnt_o(cnt), .term_o(term), .wrap_o(wrap)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int CTRL_A = CH_BASE + CH_STRIDE * i;
        localparam int VAL_A  = CTRL_A + CH_VAL_OFS;

        pwm_chan #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .tick(tick),
            .buffered(buffered), .wrap(wrap),
            .wr_ctrl(bus_wr && bus_addr == ADDR_W'(CTRL_A)),
            .wr_val(bus_wr && bus_addr == ADDR_W'(VAL_A)),
            .wctrl(bus_wdata[7:0]), .wval(bus_wdata[CNT_W-1:0]),
            .ctrl_o(ch_ctrl[i]), .val_o(ch_val[i]), .pwm_o(pwm_out[i])
        );

        AST_FLAG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_ctrl[i][7]) |-> $past(mode_q == CM_CLK)) else $error("flag set while stopped"); // R9
    end

    // Read multiplexer over global and per-channel registers.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_INFO))  bus_rdata[7:0] = 8'(NUM_CH);
        if (bus_addr == ADDR_W'(OFS_CTRL))  bus_rdata[MODE_LO+1:0] = {mode_q, ps_q};
        if (bus_addr == ADDR_W'(OFS_COUNT)) bus_rdata[CNT_W-1:0] = cnt;
        if (bus_addr == ADDR_W'(OFS_TERM))  bus_rdata[CNT_W-1:0] = term;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i))
                bus_rdata[7:0] = ch_ctrl[i];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + CH_VAL_OFS))
                bus_rdata[CNT_W-1:0] = ch_val[i];
        end
    end

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != CM_CLK) |=> $stable(cnt)) else $error("count moved while held"); // R2
endmodule

// File: tb/sim_shared_pwm_timer.sv
// Directed bench for shared_pwm_timer: one task per scenario.
module sim_shared_pwm_timer;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    int ones [NCH];
    bit done = 0;

    always #2 clk = ~clk;

    shared_pwm_timer #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        @(negedge clk);
        bus_addr = 8'(a);
        #1 d = int'(bus_rdata);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(int n);
        for (int c = 0; c < NCH; c++) ones[c] = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
            for (int c = 0; c < NCH; c++) ones[c] += int'(pwm_out[c]);
        end
    endtask

    task automatic t_reset();
        int d;
        rd('h04, d); chk("R1", "channel count", d & 'hFF, NCH);
        rd('h10, d); chk("R1", "control after reset", d, 0);
        rd('h14, d); chk("R1", "count after reset", d, 0);
        rd('h18, d); chk("R1", "terminal after reset", d, 0);
        rd('h20, d); chk("R1", "ch0 control after reset", d, 0);
        chk("R1", "outputs after reset", int'(pwm_out), 0);
    endtask

    task automatic t_stopped_writes();
        int d;
        wr('h18, 9);  rd('h18, d); chk("R5", "terminal direct while stopped", d, 9);
        wr('h24, 3);  rd('h24, d); chk("R5", "ch0 compare direct while stopped", d, 3);
        wr('h2C, 7);  wr('h34, 0);  wr('h3C, 12);
        rd('h2C, d); chk("R5", "ch1 compare direct", d, 7);
        wr('h14, 5);  rd('h14, d); chk("R3", "count write ignored", d, 0);
    endtask

    task automatic t_hold_mode();
        int d;
        wr('h20 + 0, 0);
        wr('h10, 'h20); rd('h10, d); chk("R2", "center bit reads zero", d, 0);
        wr('h10, 'h10);
        wr('h18, 20); rd('h18, d); chk("R5", "terminal buffered in mode 2'b10", d, 9);
        idle(10);
        rd('h14, d); chk("R2", "count held in mode 2'b10", d, 0);
        wr('h10, 0);
        wr('h18, 9); rd('h18, d); chk("R5", "terminal restored while stopped", d, 9);
    endtask

    task automatic t_basic();
        int d, c, hi;
        for (int i = 0; i < NCH; i++) wr('h20 + 8 * i, 'h28);
        wr('h10, 'h08);
        idle(12);
        hi = 0;
        for (int k = 0; k < 20; k++) begin
            rd('h14, c);
            if (c > 9) hi++;
        end
        chk("R3", "count never above terminal", hi, 0);
        for (int k = 0; k < 10; k++) begin
            rd('h14, c);
            chk("R10", "ch0 tracks shared count", int'(pwm_out[0]), int'(c < 3));
            chk("R10", "ch1 tracks shared count", int'(pwm_out[1]), int'(c < 7));
        end
        measure(30);
        chk("R4", "ch0 high cycles duty 3/10", ones[0], 9);
        chk("R4", "ch1 high cycles duty 7/10", ones[1], 21);
        chk("R6", "ch2 compare 0 never high", ones[2], 0);
        chk("R6", "ch3 compare above terminal always high", ones[3], 30);
    endtask

    task automatic t_prescale();
        wr('h10, 'h0A);
        idle(8);
        measure(80);
        chk("R2", "ch0 high cycles with ps=2", ones[0], 24);
        chk("R2", "ch1 high cycles with ps=2", ones[1], 56);
        wr('h10, 'h08);
        idle(12);
    endtask

    task automatic t_buffered();
        int d, n;
        wr('h18, 14);
        rd('h18, d); chk("R5", "terminal held while running", d, 9);
        n = 0;
        do begin rd('h18, d); n++; end while (d != 14 && n < 40);
        chk("R5", "terminal applied within one period", int'(d == 14 && n <= 12), 1);
        wr('h24, 5);
        rd('h24, d); chk("R5", "compare held while running", d, 3);
        n = 0;
        do begin rd('h24, d); n++; end while (d != 5 && n < 40);
        chk("R5", "compare applied within one period", int'(d == 5 && n <= 17), 1);
        measure(30);
        chk("R4", "ch0 high cycles duty 5/15", ones[0], 10);
        chk("R10", "ch1 follows new period", ones[1], 14);
        chk("R10", "ch3 follows new period", ones[3], 24);
    endtask

    task automatic t_polarity();
        int c;
        wr('h20, 'h24);
        bus_addr = 8'h14;
        for (int k = 0; k < 6; k++) begin
            #1 c = int'(bus_rdata);
            chk("R7", "inverted output at once", int'(pwm_out[0]), int'(c >= 5));
            @(negedge clk);
        end
        measure(30);
        chk("R7", "ch0 inverted high cycles", ones[0], 20);
    endtask

    task automatic t_disable();
        wr('h20, 'h00); measure(30); chk("R8", "ch0 all-zero control low", ones[0], 0);
        wr('h20, 'h2C); measure(30); chk("R8", "ch0 level 2'b11 low", ones[0], 0);
        wr('h20, 'h08); measure(30); chk("R8", "ch0 bit5 clear low", ones[0], 0);
        wr('h20, 'h28);
    endtask

    task automatic t_flag();
        int d, c0, c1;
        wr('h10, 0);
        rd('h28, d); chk("R9", "ch1 flag set after matches", d, 'hA8);
        wr('h28, 'h28); rd('h28, d); chk("R9", "write 0 keeps flag", d, 'hA8);
        wr('h28, 'hA8); rd('h28, d); chk("R9", "write 1 clears flag", d, 'h28);
        rd('h14, c0);
        idle(20);
        rd('h14, c1); chk("R2", "count stable while stopped", c1, c0);
        rd('h28, d); chk("R9", "no flag while stopped", d, 'h28);
        wr('h10, 'h08); idle(20); wr('h10, 0);
        rd('h28, d); chk("R9", "flag sets again on running match", d, 'hA8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL all watchdog: actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stopped_writes();
        t_hold_mode();
        t_basic();
        t_prescale();
        t_buffered();
        t_polarity();
        t_disable();
        t_flag();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule